// File: doc/BRIEF.md
# Half-Step Stepper Phase Sequencer

This block steps the four coils of a unipolar stepper motor through an eight-state half-step cycle. The outputs are active-low: a 0 on a bit energises that coil. The cycle alternates between one energised coil and two adjacent energised coils, so each step moves the rotor half a full step. A `reverse` input picks the walking direction, and `enable` lets stepping run or pauses it.

The block runs on the fast system clock. A free-running prescaler of `PRESCALE_W` bits produces a one-cycle `step_tick` once every 2^`PRESCALE_W` cycles, at the moment its top bit is about to rise. The state machine advances only on that tick. The slow rate therefore costs no derived clock. A shorter prescaler can be chosen for simulation.

The state machine has eight states, named after the coils they energise (coils Q3..Q0 map to phase bits 3..0): ST_Q1 (1101), ST_Q1Q0 (1100), ST_Q0 (1110), ST_Q3Q0 (0110), ST_Q3 (0111), ST_Q3Q2 (0011), ST_Q2 (1011), ST_Q2Q1 (1001). There are three transitions:
- **Forward transition:** taken on a tick with `enable`=1 and `reverse`=0, it moves to the next state in the list above, wrapping from ST_Q2Q1 to ST_Q1.
- **Reverse transition:** taken on a tick with `enable`=1 and `reverse`=1, it moves to the previous state, wrapping from ST_Q1 to ST_Q2Q1.
- **Hold:** taken in every other cycle, it keeps the state.

Top module: `halfstep_sequencer`

## Requirements
- R1: A synchronous active-high `rst` puts the state machine in ST_Q1 (phase_n=1101) and clears the prescaler. After `rst` is released, `step_tick` is first high in cycle 2^(PRESCALE_W-1)-1, counting that cycle as 0. The phase changes on the edge that follows.
- R2: With `enable`=1 and `reverse`=0, each tick moves phase_n along 1101, 1100, 1110, 0110, 0111, 0011, 1011, 1001, then back to 1101.
- R3: With `enable`=1 and `reverse`=1, each tick walks the same eight codes in the opposite order, wrapping from 1101 to 1001.
- R4: A change of direction starts from the current state and needs no reset. For example, at 0011 a reverse tick gives 0111. Successive codes in the cycle always differ in exactly one bit.
- R5: `step_tick` is high for exactly one cycle in every 2^PRESCALE_W cycles, and with `enable`=1 each phase code stays on the output for exactly 2^PRESCALE_W cycles.
- R6: With `enable`=0 the state does not change on a tick. When IDLE_OFF=0, phase_n keeps showing the held code.
- R7: When IDLE_OFF=1, phase_n is 1111 (all coils off) while `enable`=0. Once `enable` returns, stepping resumes from the held state.
- R8: `reverse` is sampled only on a tick: toggling it between ticks has no effect on the phase or on the next step.
- R9: Whenever coils are driven, phase_n has exactly one or two bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 = step on ticks, 0 = pause |
| reverse | input | 1 | 0 = forward cycle, 1 = reverse cycle |
| phase_n | output | 4 | Active-low coil drives, bit n for coil Qn |
| step_tick | output | 1 | One-cycle pulse in the cycle before a step edge |

## Verification
The embedded assertions assume three things about the inputs:
- `rst` is asserted at time zero.
- Any mid-run reset lasts at least one clock edge.
- `enable` and `reverse` are synchronous to `clk`.

Under those conditions, the one-bit-move property is only checked across cycles where `enable` was high both times. The stimulus changes `enable` and `reverse` only at falling edges. It changes them mid-step or right after a step edge, never in the tick cycle itself, so the inputs are settled at every sampling edge. The prescaler is shortened to 4 bits so that each step takes 16 cycles.

// File: rtl/hs_pkg.sv
package hs_pkg;

    // Coils Q3..Q0 drive phase bits 3..0; names list the energised coils.
    typedef enum logic [2:0] {
        ST_Q1   = 3'd0,
        ST_Q1Q0 = 3'd1,
        ST_Q0   = 3'd2,
        ST_Q3Q0 = 3'd3,
        ST_Q3   = 3'd4,
        ST_Q3Q2 = 3'd5,
        ST_Q2   = 3'd6,
        ST_Q2Q1 = 3'd7
    } hs_state_e;

    localparam int unsigned PHASE_W   = 4;
    localparam logic [PHASE_W-1:0] PHASE_ALL_OFF = '1;
    localparam hs_state_e   RESET_STATE = ST_Q1;

endpackage

// File: rtl/hs_prescaler.sv
module hs_prescaler #(
    parameter int unsigned PRESCALE_W = 17  // must be at least 2
) (
    input  logic clk,
    input  logic rst,
    output logic step_tick
);

    // Tick in the cycle just before the top bit of the counter rises.
    localparam logic [PRESCALE_W-1:0] TICK_AT = {1'b0, {(PRESCALE_W-1){1'b1}}};

    logic [PRESCALE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign step_tick = (cnt_q == TICK_AT);

    // R5: a tick is a single-cycle pulse
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
        step_tick |=> !step_tick);

    // R5: the edge after a tick is the one where the top counter bit rises
    assert_tick_on_top_rise_R5: assert property (@(posedge clk) disable iff (rst)
        step_tick |=> $rose(cnt_q[PRESCALE_W-1]));

endmodule

// File: rtl/hs_step_fsm.sv
module hs_step_fsm
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_tick,
    input  logic      enable,
    input  logic      reverse,
    output hs_state_e state
);

    hs_state_e state_q, state_d;
    logic      take_step;

    assign take_step = step_tick && enable;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RESET_STATE;
        else     state_q <= state_d;
    end

    // Next-state: forward transition, reverse transition, or hold
    always_comb begin
        state_d = state_q;
        if (take_step) begin
            unique case (state_q)
                ST_Q1:   state_d = reverse ? ST_Q2Q1 : ST_Q1Q0;
                ST_Q1Q0: state_d = reverse ? ST_Q1   : ST_Q0;
                ST_Q0:   state_d = reverse ? ST_Q1Q0 : ST_Q3Q0;
                ST_Q3Q0: state_d = reverse ? ST_Q0   : ST_Q3;
                ST_Q3:   state_d = reverse ? ST_Q3Q0 : ST_Q3Q2;
                ST_Q3Q2: state_d = reverse ? ST_Q3   : ST_Q2;
                ST_Q2:   state_d = reverse ? ST_Q3Q2 : ST_Q2Q1;
                ST_Q2Q1: state_d = reverse ? ST_Q2   : ST_Q1;
                default: state_d = RESET_STATE;
            endcase
        end
    end

    assign state = state_q;

    // R5: an enabled tick always moves the state
    assert_step_moves_R5: assert property (@(posedge clk) disable iff (rst)
        take_step |=> state_q != $past(state_q));

    // R6 / R8: no state change without an enabled tick
    assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (rst)
        !take_step |=> $stable(state_q));

endmodule

// File: rtl/hs_phase_encoder.sv
module hs_phase_encoder
    import hs_pkg::*;
#(
    parameter bit IDLE_OFF = 1'b0
) (
    input  hs_state_e            state,
    input  logic                 enable,
    output logic [PHASE_W-1:0]   phase_n
);

    logic [PHASE_W-1:0] code_n;
    logic               coils_off;

    // Output process: active-low code per state
    always_comb begin
        unique case (state)
            ST_Q1:   code_n = 4'b1101;
            ST_Q1Q0: code_n = 4'b1100;
            ST_Q0:   code_n = 4'b1110;
            ST_Q3Q0: code_n = 4'b0110;
            ST_Q3:   code_n = 4'b0111;
            ST_Q3Q2: code_n = 4'b0011;
            ST_Q2:   code_n = 4'b1011;
            ST_Q2Q1: code_n = 4'b1001;
            default: code_n = PHASE_ALL_OFF;
        endcase
    end

    generate
        if (IDLE_OFF) begin : g_idle_off
            assign coils_off = !enable;
        end else begin : g_idle_hold
            assign coils_off = 1'b0;
        end
    endgenerate

    assign phase_n = coils_off ? PHASE_ALL_OFF : code_n;

endmodule

// File: rtl/halfstep_sequencer.sv
module halfstep_sequencer
    import hs_pkg::*;
#(
    parameter int unsigned PRESCALE_W = 17,
    parameter bit          IDLE_OFF   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       reverse,
    output logic [3:0] phase_n,
    output logic       step_tick
);

    hs_state_e state;

    hs_prescaler #(.PRESCALE_W(PRESCALE_W)) presc_i (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick)
    );

    hs_step_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick),
        .enable    (enable),
        .reverse   (reverse),
        .state     (state)
    );

    hs_phase_encoder #(.IDLE_OFF(IDLE_OFF)) enc_i (
        .state   (state),
        .enable  (enable),
        .phase_n (phase_n)
    );

    // R9: one or two coils driven whenever coils are on
    assert_drive_shape_R9: assert property (@(posedge clk) disable iff (rst)
        (enable || !IDLE_OFF) |->
            ($countones(~phase_n) == 1 || $countones(~phase_n) == 2));

    // R4: any step, either direction, moves exactly one coil
    assert_single_bit_move_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && enable && $past(enable) && !$stable(phase_n)) |->
            $countones(phase_n ^ $past(phase_n)) == 1);

endmodule

// File: tb/halfstep_sequencer_tb_top.sv
module halfstep_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PRESC_W    = 4;
    localparam int STEP_CYC   = 1 << PRESC_W;
    localparam int HALF_CYC   = STEP_CYC / 2;
    localparam int NVEC       = 13;

    // {enable, reverse, expected code after the tick}
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        6'b10_1110, 6'b10_0110, 6'b10_0111, 6'b10_0011,
        6'b11_0111, 6'b11_0110, 6'b11_1110, 6'b11_1100,
        6'b11_1101, 6'b11_1001, 6'b01_1001, 6'b10_1101,
        6'b10_1100
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       reverse = 1'b0;
    logic [3:0] phase_a, phase_b;
    logic       tick_a, tick_b;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfstep_sequencer #(.PRESCALE_W(PRESC_W), .IDLE_OFF(1'b0)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .reverse(reverse),
        .phase_n(phase_a), .step_tick(tick_a)
    );

    halfstep_sequencer #(.PRESCALE_W(PRESC_W), .IDLE_OFF(1'b1)) dut_idle_i (
        .clk(clk), .rst(rst), .enable(enable), .reverse(reverse),
        .phase_n(phase_b), .step_tick(tick_b)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 reset phase", phase_a, 4'b1101);
        check("R1 reset tick", {3'b0, tick_a}, 4'b0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R5 no tick at count 6", {3'b0, tick_a}, 4'b0);
        @(posedge clk);
        @(negedge clk);
        check("R5 tick at count 7", {3'b0, tick_a}, 4'b1);
        check("R1 phase before first step", phase_a, 4'b1101);
        @(posedge clk);
        @(negedge clk);
        check("R2 first forward step", phase_a, 4'b1100);
        check("R5 tick drops", {3'b0, tick_a}, 4'b0);
        prev = 4'b1100;

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            string req;
            enable  = VEC[i][5];
            reverse = VEC[i][4];
            if (!VEC[i][5])     req = "R6 hold while disabled";
            else if (i == 4)    req = "R4 direction change";
            else if (VEC[i][4]) req = "R3 reverse step";
            else                req = "R2 forward step";
            repeat (HALF_CYC) @(posedge clk);
            @(negedge clk);
            check("R5 code held mid-step", phase_a, prev);
            repeat (HALF_CYC) @(posedge clk);
            @(negedge clk);
            check(req, phase_a, VEC[i][3:0]);
            check(VEC[i][5] ? "R7 resumes tracking" : "R7 coils off when disabled",
                  phase_b, VEC[i][5] ? VEC[i][3:0] : 4'b1111);
            prev = VEC[i][3:0];
        end

        // R8: reverse toggled between ticks is ignored
        enable  = 1'b1;
        reverse = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 mid-step reverse no effect", phase_a, 4'b1100);
        reverse = 1'b0;
        repeat (STEP_CYC - 5) @(posedge clk);
        @(negedge clk);
        check("R8 next step still forward", phase_a, 4'b1110);

        // R1: mid-run reset clears state and prescaler
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset phase", phase_a, 4'b1101);
        check("R1 mid-run reset idle-off dut", phase_b, 4'b1101);
        repeat (HALF_CYC - 1) @(posedge clk);
        @(negedge clk);
        check("R1 prescaler cleared, no step yet", phase_a, 4'b1101);
        @(posedge clk);
        @(negedge clk);
        check("R1 first step after reset", phase_a, 4'b1100);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule